// File: doc/BRIEF.md
# Booth Final-Row Negating Partial Product Generator

This combinational unit builds the last partial product row of a radix-4 Booth multiplier in finished two's complement form. A normal Booth row carries a separate negation bit that the summation stage must add at the row's least significant position. That bit makes the last column one entry taller. Here the negated multiplicand is formed inside the unit, so the row leaves with no such bit and the summation array keeps its height.

The 3-bit Booth group is decoded into five one-hot selects: zero, +X, +2X, -X and -2X. In parallel, -X is formed as the inverted multiplicand plus one. The increment uses a prefix tree, so its depth grows with the logarithm of the width. A row of 4-to-1 AND-OR multiplexers then picks one of the four non-zero multiples for each bit. When no select is active, the multiplexer output is zero. The row is N+2 bits wide and sign-extended, which leaves room for +2X of the most negative multiplicand.

Top module: `booth_lastrow_gen`

## Requirements
- R1: Groups 3'b000 and 3'b111 give an all-zero row, whatever the multiplicand.
- R2: Groups 3'b001 and 3'b010 give the multiplicand, sign-extended to N+2 bits.
- R3: Group 3'b011 gives twice the multiplicand as a signed N+2 bit value, with bit 0 equal to zero.
- R4: Group 3'b100 gives minus twice the multiplicand as a signed N+2 bit value, with bit 0 equal to zero.
- R5: Groups 3'b101 and 3'b110 give minus the multiplicand, sign-extended to N+2 bits.
- R6: For the most negative multiplicand (8'h80 at N=8), group 3'b101 gives +128 (10'h080) and group 3'b100 gives +256 (10'h100), with no overflow.
- R7: For every multiplicand and every group, the row read as a signed value equals (-2*g[2] + g[1] + g[0]) times the signed multiplicand.
- R8: A zero multiplicand gives an all-zero row for the negating groups too: the carry that runs out of the full increment is dropped.
- R9: The unit has no state, and the row follows any change of its inputs within the same clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | N | Signed multiplicand X |
| grp | input | 3 | Booth group for the last row, bit 2 most significant |
| row | output | N+2 | Selected multiple of X in two's complement |

## Verification
The increment carry running across the full width and the left shift that forms -2X can both be needed in the same evaluation. This happens when group 3'b100 is applied to multiplicands whose inverse is all ones or nearly all ones, such as 8'h00 and 8'h80. Those vectors are placed in the table. Every (multiplicand, group) pair is then swept and compared with a signed product computed in the bench. A dropped end carry or a misplaced shift shows up as a wrong row value.

// File: rtl/booth_lr_pkg.sv
package booth_lr_pkg;

    typedef struct packed {
        logic zero;
        logic pos1;
        logic pos2;
        logic neg1;
        logic neg2;
    } mult_sel_t;

    function automatic mult_sel_t decode_group(input logic [2:0] g);
        mult_sel_t s;
        s = '0;
        unique case (g)
            3'b000, 3'b111: s.zero = 1'b1;
            3'b001, 3'b010: s.pos1 = 1'b1;
            3'b011:         s.pos2 = 1'b1;
            3'b100:         s.neg2 = 1'b1;
            default:        s.neg1 = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/booth_sel_decoder.sv
module booth_sel_decoder
    import booth_lr_pkg::*;
(
    input  logic [2:0] grp,
    output mult_sel_t  sel
);
    always_comb sel = decode_group(grp);
endmodule

// File: rtl/prefix_incrementer.sv
module prefix_incrementer #(
    parameter int W = 9
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    localparam int L = (W > 1) ? $clog2(W) : 1;

    logic [L:0][W-1:0] pre;
    logic [W-1:0]      cin;

    assign pre[0] = a;

    for (genvar l = 0; l < L; l++) begin : g_lvl
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= (1 << l)) begin : g_join
                assign pre[l+1][i] = pre[l][i] & pre[l][i-(1<<l)];
            end else begin : g_pass
                assign pre[l+1][i] = pre[l][i];
            end
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_sum
        if (i == 0) begin : g_lsb
            assign cin[i] = 1'b1;
        end else begin : g_hi
            assign cin[i] = pre[L][i-1];
        end
        assign y[i] = a[i] ^ cin[i];
    end

    // R7: the prefix tree must match an arithmetic increment
    always_comb begin
        p_inc_exact_r7: assert (y == W'(a + 1'b1))
            else $error("prefix incrementer mismatch");
    end
endmodule

// File: rtl/zero_mux_row.sv
module zero_mux_row #(
    parameter int W = 10
) (
    input  logic [3:0]   sel,
    input  logic [W-1:0] d0,
    input  logic [W-1:0] d1,
    input  logic [W-1:0] d2,
    input  logic [W-1:0] d3,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_col
        assign q[i] = |(sel & {d3[i], d2[i], d1[i], d0[i]});
    end

    // R1: at most one data input may be steered to the row
    always_comb begin
        p_sel_onehot0_r1: assert ($onehot0(sel))
            else $error("more than one mux select active");
    end
endmodule

// File: rtl/booth_lastrow_gen.sv
module booth_lastrow_gen
    import booth_lr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] mcand,
    input  logic [2:0]   grp,
    output logic [N+1:0] row
);
    localparam int WE = N + 1;
    localparam int WR = N + 2;

    mult_sel_t     sel;
    logic [WE-1:0] x_ext;
    logic [WE-1:0] neg_x;
    logic [WR-1:0] m_p1, m_p2, m_n1, m_n2;

    booth_sel_decoder u_dec (
        .grp (grp),
        .sel (sel)
    );

    assign x_ext = {mcand[N-1], mcand};

    prefix_incrementer #(.W(WE)) u_inc (
        .a (~x_ext),
        .y (neg_x)
    );

    assign m_p1 = {x_ext[WE-1], x_ext};
    assign m_p2 = {x_ext, 1'b0};
    assign m_n1 = {neg_x[WE-1], neg_x};
    assign m_n2 = {neg_x, 1'b0};

    zero_mux_row #(.W(WR)) u_mux (
        .sel ({sel.neg2, sel.neg1, sel.pos2, sel.pos1}),
        .d0  (m_p1),
        .d1  (m_p2),
        .d2  (m_n1),
        .d3  (m_n2),
        .q   (row)
    );

    always_comb begin
        // R1: a zero select empties the row
        p_zero_row_r1: assert (!sel.zero || row == '0)
            else $error("zero group gave nonzero row");
        // R2: +X select passes the sign-extended multiplicand
        p_pos_row_r2: assert (!sel.pos1 || row == {{2{mcand[N-1]}}, mcand})
            else $error("+X row wrong");
        // R4: doubled negative multiple has a clear low bit
        p_neg2_lsb_r4: assert (!sel.neg2 || row[0] == 1'b0)
            else $error("-2X row low bit set");
        // R5: -X row plus X is zero modulo the row width
        p_neg_sum_r5: assert (!sel.neg1 || WR'(row + {{2{mcand[N-1]}}, mcand}) == '0)
            else $error("-X row wrong");
    end
endmodule

// File: tb/sim_booth_lastrow_gen.sv
module sim_booth_lastrow_gen;
    localparam int N  = 8;
    localparam int WR = N + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  mcand = '0;
    logic [2:0]    grp = '0;
    logic [WR-1:0] row;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    booth_lastrow_gen #(.N(N)) u0 (
        .mcand (mcand),
        .grp   (grp),
        .row   (row)
    );

    // {mcand, grp, expected row}
    localparam int NV = 15;
    localparam logic [20:0] VEC [NV] = '{
        {8'h05, 3'd0, 10'h000},  // R1
        {8'h05, 3'd7, 10'h000},  // R1
        {8'h05, 3'd1, 10'h005},  // R2
        {8'h05, 3'd2, 10'h005},  // R2
        {8'h05, 3'd3, 10'h00A},  // R3
        {8'h05, 3'd4, 10'h3F6},  // R4
        {8'h05, 3'd5, 10'h3FB},  // R5
        {8'h05, 3'd6, 10'h3FB},  // R5
        {8'h80, 3'd5, 10'h080},  // R6
        {8'h80, 3'd4, 10'h100},  // R6
        {8'h80, 3'd1, 10'h380},  // R2
        {8'h80, 3'd3, 10'h300},  // R3
        {8'h7F, 3'd4, 10'h302},  // R4
        {8'h00, 3'd4, 10'h000},  // R8
        {8'hFF, 3'd5, 10'h001}   // R5
    };

    task automatic check(input string req, input logic [WR-1:0] exp);
        n_chk++;
        if (row !== exp) begin
            n_fail++;
            $display("FAIL %s mcand=%h grp=%b row=%h expected=%h", req, mcand, grp, row, exp);
        end
    endtask

    function automatic logic [WR-1:0] ref_row(input logic [N-1:0] x, input logic [2:0] g);
        int f, v;
        f = -2 * int'(g[2]) + int'(g[1]) + int'(g[0]);
        v = int'($signed(x)) * f;
        return v[WR-1:0];
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 reset", 10'h000);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            @(posedge clk);
            {mcand, grp} = VEC[k][20:10];
            @(negedge clk);
            check("R1-6 table", VEC[k][9:0]);
        end

        // R8: zero multiplicand with every group
        for (int g = 0; g < 8; g++) begin
            @(posedge clk);
            mcand = '0;
            grp = 3'(g);
            @(negedge clk);
            check("R8", '0);
        end

        // R9: row follows input changes within one period, no clock needed
        @(posedge clk);
        mcand = 8'h11; grp = 3'd3;
        #1 check("R9", 10'h022);
        mcand = 8'h11; grp = 3'd6;
        #1 check("R9", 10'h3EF);

        // R7: exhaustive sweep
        for (int x = 0; x < 256; x++) begin
            for (int g = 0; g < 8; g++) begin
                @(posedge clk);
                mcand = 8'(x);
                grp = 3'(g);
                @(negedge clk);
                check("R7", ref_row(mcand, grp));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule